// File: doc/BRIEF.md
# Load-Use Hazard Counter

This block watches a stream of retired instructions, taking at most one per clock when `in_valid` is high. Each instruction brings up to three source register indices and up to two destination register indices, each with its own use bit, plus two flags: one marking a memory access and one marking a load. Register indices arrive already mapped into one flat space: general registers at 0–31, floating-point registers at 32–63, and special registers such as HI and LO above 63.

For every register the block keeps a ready time, counted in retired instructions. A load that retires as instruction N marks each destination it writes as ready at N + 2. A later instruction whose source register's ready time is still greater than its own instruction number is counted as one load-use hazard. The block only collects statistics for performance analysis. It never stalls or forwards anything.

Top module: `lduse_monitor`

## Requirements
- R1: After reset, both counters read 0 and every ready time is 0, so the first instructions after reset never count a hazard.
- R2: `insn_count` increases by exactly 1 on each clock edge where `in_valid` is high and `clr` is low, and holds when `in_valid` is low.
- R3: Number each valid instruction by the value `insn_count` takes after it is counted. When a load retires as instruction N, every destination slot it uses gets ready time N + 2. The next instruction (N + 1) that reads such a register adds 1 to `hazard_count`.
- R4: A hazard is counted only when a used source's ready time is strictly greater than the current instruction number. An instruction two or more places after the load therefore counts no hazard on that register.
- R5: An instruction adds at most 1 to `hazard_count`, even when several of its sources are not ready.
- R6: A source or destination slot whose use bit is 0 is ignored, both for the hazard check and for the ready-time update.
- R7: Ready times change only for instructions with both `is_mem` and `is_load` high. A store (`is_mem` high, `is_load` low) and an instruction with `is_load` high but `is_mem` low leave the table unchanged.
- R8: The hazard check for an instruction uses the ready times from before that instruction's own update. A load reading the register it writes is judged only on earlier loads.
- R9: A high `clr` on a clock edge zeroes both counters and all ready times. It takes priority over a valid instruction in the same cycle, and that instruction is dropped.
- R10: Every index from 0 to NREG-1 (default 72) has its own ready time. For example, index 0 and index 32 are independent, and index 71 is usable.
- R11: The counter outputs are registered. The effect of an instruction appears on the outputs after the clock edge that accepts it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Synchronous clear of counters and ready table |
| in_valid | input | 1 | One instruction retires this cycle |
| is_mem | input | 1 | Instruction accesses memory |
| is_load | input | 1 | Instruction is a load |
| src_reg | input | 3x7 | Flat source register indices, one per slot |
| src_use | input | 3 | Use bit for each source slot |
| dst_reg | input | 2x7 | Flat destination register indices, one per slot |
| dst_use | input | 2 | Use bit for each destination slot |
| insn_count | output | 32 | Retired instructions since reset or clear |
| hazard_count | output | 32 | Load-use hazards since reset or clear |

## Verification
The assertions assume that every used register slot carries an index below NREG. An index at or above NREG has no table entry, and the logic treats it as always ready. The bench draws its random indices only from pools inside the table: a few low general registers, some floating-point indices and the top entries near 71. The directed cases also stay within the table. The pools are kept small so that random loads and their consumers collide often. Clears and idle cycles are mixed in at low rates so that the counting checks see every kind of cycle.

// File: rtl/lduse_monitor.sv
module lduse_monitor #(
  parameter int NREG = 72,
  parameter int CW   = 32,
  parameter int NSRC = 3,
  parameter int NDST = 2,
  localparam int RW  = $clog2(NREG)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      clr,
  input  logic                      in_valid,
  input  logic                      is_mem,
  input  logic                      is_load,
  input  logic [NSRC-1:0][RW-1:0]   src_reg,
  input  logic [NSRC-1:0]           src_use,
  input  logic [NDST-1:0][RW-1:0]   dst_reg,
  input  logic [NDST-1:0]           dst_use,
  output logic [CW-1:0]             insn_count,
  output logic [CW-1:0]             hazard_count
);

  localparam logic [RW:0] LIMIT = (RW+1)'(NREG);

  logic [CW-1:0] ready [NREG];
  logic [CW-1:0] n_next;
  logic          hit;
  logic          upd;

  assign n_next = insn_count + CW'(1);
  assign upd    = is_mem && is_load;

  always_comb begin
    hit = 1'b0;
    for (int i = 0; i < NSRC; i++)
      if (src_use[i] && ({1'b0, src_reg[i]} < LIMIT))
        if (ready[src_reg[i]] > n_next) hit = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      insn_count   <= '0;
      hazard_count <= '0;
      for (int k = 0; k < NREG; k++) ready[k] <= '0;
    end else if (clr) begin
      insn_count   <= '0;
      hazard_count <= '0;
      for (int k = 0; k < NREG; k++) ready[k] <= '0;
    end else if (in_valid) begin
      insn_count <= n_next;
      if (hit) hazard_count <= hazard_count + CW'(1);
      for (int j = 0; j < NDST; j++)
        if (upd && dst_use[j] && ({1'b0, dst_reg[j]} < LIMIT))
          ready[dst_reg[j]] <= n_next + CW'(2);
    end
  end

  p_src_in_table_r10: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> ((!src_use[0] || {1'b0, src_reg[0]} < LIMIT) &&
                  (!src_use[1] || {1'b0, src_reg[1]} < LIMIT) &&
                  (!src_use[2] || {1'b0, src_reg[2]} < LIMIT)));

  p_dst_in_table_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && upd) |-> ((!dst_use[0] || {1'b0, dst_reg[0]} < LIMIT) &&
                           (!dst_use[1] || {1'b0, dst_reg[1]} < LIMIT)));

  p_count_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !clr) |=> insn_count == $past(insn_count) + CW'(1));

  p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_valid && !clr) |=> ($stable(insn_count) && $stable(hazard_count)));

  p_one_hazard_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !clr) |=> (hazard_count == $past(hazard_count) ||
                            hazard_count == $past(hazard_count) + CW'(1)));

  p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (insn_count == '0 && hazard_count == '0));

  p_first_clean_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (insn_count == '0 && !clr) |=> hazard_count == '0);

endmodule

// File: tb/lduse_monitor_test.sv
`timescale 1ns/1ps
module lduse_monitor_test;
  localparam int NREG = 72;

  logic clk = 0, rst_n = 0, clr = 0, in_valid = 0, is_mem = 0, is_load = 0;
  logic [2:0][6:0] src_reg = '0;
  logic [2:0]      src_use = '0;
  logic [1:0][6:0] dst_reg = '0;
  logic [1:0]      dst_use = '0;
  logic [31:0]     insn_count, hazard_count;

  int checks = 0, failures = 0;
  bit done = 0;
  int unsigned m_rdy [NREG];
  int unsigned m_ins = 0, m_haz = 0;

  always #5 clk = ~clk;

  lduse_monitor uut (.clk(clk), .rst_n(rst_n), .clr(clr), .in_valid(in_valid),
    .is_mem(is_mem), .is_load(is_load), .src_reg(src_reg), .src_use(src_use),
    .dst_reg(dst_reg), .dst_use(dst_use), .insn_count(insn_count),
    .hazard_count(hazard_count));

  function automatic bit model_hit(logic [2:0][6:0] s, logic [2:0] su, int unsigned n);
    for (int i = 0; i < 3; i++)
      if (su[i] && m_rdy[s[i]] > n) return 1;
    return 0;
  endfunction

  task automatic check(string tag);
    checks++;
    if (insn_count !== m_ins || hazard_count !== m_haz) begin
      failures++;
      $display("FAIL %s: insn=%0d haz=%0d expected insn=%0d haz=%0d",
               tag, insn_count, hazard_count, m_ins, m_haz);
    end
  endtask

  task automatic step(string tag, bit v, bit m, bit l, logic [2:0][6:0] s,
                      logic [2:0] su, logic [1:0][6:0] d, logic [1:0] du, bit c);
    int unsigned n;
    in_valid = v; is_mem = m; is_load = l; src_reg = s; src_use = su;
    dst_reg = d; dst_use = du; clr = c;
    if (c) begin
      m_ins = 0; m_haz = 0;
      for (int k = 0; k < NREG; k++) m_rdy[k] = 0;
    end else if (v) begin
      n = m_ins + 1;
      if (model_hit(s, su, n)) m_haz++;
      if (m && l)
        for (int j = 0; j < 2; j++) if (du[j]) m_rdy[d[j]] = n + 2;
      m_ins = n;
    end
    @(negedge clk);
    check(tag);
  endtask

  task automatic ld(string tag, int a, int b, logic [1:0] du, int sa);
    step(tag, 1, 1, 1, {7'd0, 7'd0, 7'(sa)}, 3'b001, {7'(b), 7'(a)}, du, 0);
  endtask
  task automatic use3(string tag, int a, int b, int c, logic [2:0] su);
    step(tag, 1, 0, 0, {7'(c), 7'(b), 7'(a)}, su, '0, 2'b00, 0);
  endtask

  function automatic logic [6:0] pick();
    int unsigned r = $urandom_range(0, 11);
    if (r < 6) return 7'(r);
    if (r < 9) return 7'(32 + r - 6);
    return 7'(NREG - 1 - (r - 9));
  endfunction

  initial begin
    #2_000_000;
    if (!done) begin
      failures++; checks++;
      $display("FAIL watchdog: expired, expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    for (int k = 0; k < NREG; k++) m_rdy[k] = 0;
    @(negedge clk); @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1 reset");
    use3("R1 no hazard after reset", 5, 6, 7, 3'b111);

    ld("R3 load r5", 5, 0, 2'b01, 0);
    use3("R3 next reads r5", 5, 0, 0, 3'b001);
    ld("R4 load r6", 6, 0, 2'b01, 0);
    use3("R4 gap", 1, 0, 0, 3'b000);
    use3("R4 two after load", 6, 0, 0, 3'b001);
    ld("R5 load r7 r8", 7, 8, 2'b11, 0);
    use3("R5 three stale sources", 7, 8, 7, 3'b111);
    ld("R6 dst unused", 9, 0, 2'b00, 0);
    use3("R6 reads unused dst", 9, 0, 0, 3'b001);
    ld("R6 load r10", 10, 0, 2'b01, 0);
    use3("R6 unused src slot", 10, 10, 10, 3'b000);
    step("R7 store", 1, 1, 0, '0, 3'b000, {7'd0, 7'd11}, 2'b01, 0);
    use3("R7 after store", 11, 0, 0, 3'b001);
    step("R7 load flag no mem", 1, 0, 1, '0, 3'b000, {7'd0, 7'd11}, 2'b01, 0);
    use3("R7 after non-mem load", 11, 0, 0, 3'b001);
    ld("R8 self load r13", 13, 0, 2'b01, 13);
    ld("R8 chained load r13", 13, 0, 2'b01, 13);
    use3("R8 reads r13", 13, 0, 0, 3'b001);
    ld("R10 load r71", 71, 0, 2'b01, 0);
    use3("R10 reads r71", 71, 0, 0, 3'b001);
    ld("R10 load r32", 32, 0, 2'b01, 0);
    use3("R10 reads r0", 0, 0, 0, 3'b001);
    for (int i = 0; i < 3; i++)
      step("R2 idle hold", 0, 1, 1, '0, 3'b111, {7'd1, 7'd1}, 2'b11, 0);
    ld("R9 load r14", 14, 0, 2'b01, 0);
    step("R9 clear with valid", 1, 0, 0, {7'd0, 7'd0, 7'd14}, 3'b001, '0, 2'b00, 1);
    use3("R9 reads r14 after clear", 14, 0, 0, 3'b001);
    ld("R11 load r2", 2, 0, 2'b01, 0);
    in_valid = 1; is_mem = 0; is_load = 0; src_reg = {7'd0, 7'd0, 7'd2};
    src_use = 3'b001; dst_use = 2'b00; clr = 0;
    #2;
    checks++;
    if (hazard_count !== m_haz) begin
      failures++;
      $display("FAIL R11 before edge: haz=%0d expected %0d", hazard_count, m_haz);
    end
    @(negedge clk);
    m_ins++; m_haz++;
    check("R11 after edge");

    for (int t = 0; t < 4000; t++) begin
      bit v = ($urandom_range(0, 9) < 8);
      bit c = ($urandom_range(0, 299) == 0);
      bit m = $urandom_range(0, 1);
      bit l = $urandom_range(0, 1);
      step("R3 random", v, m, l, {pick(), pick(), pick()}, 3'($urandom),
           {pick(), pick()}, 2'($urandom), c);
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule